// File: doc/BRIEF.md
# Display List Scanline Fetcher

Once per frame, this block follows a chain of row descriptors held in word-addressed memory. For each displayed row it hands one record to a downstream line renderer. A descriptor is two 16-bit words. The first is the address of the row's pixel data. The second is a link word: it points to the next descriptor, and its three low bits act as flags. One flag flips a cursor-enable state that persists from row to row. One marks the next descriptor as extended. For an extended descriptor, a third flag says whether the two words stored just before it form a palette word or a control word. A control word also reloads the cursor colour, type, pixel position and octet position, and these stay in force on later rows.

The block reads memory through a single 16-bit read port with a request/acknowledge handshake. A one-cycle frame-start pulse starts each walk. Records leave through a valid/ready port. While a record waits at the output, no memory read is outstanding. If memory fails to answer a read within a bounded number of cycles, the walk stops. The rest of the frame is then filled with blank records, so the renderer always receives the full row count.

Top module: `dlist_fetcher`

## Requirements
- R1: A frame-start pulse seen while idle begins a walk whose first read is at byte address 0270 octal (184). The cursor-enable state and all cursor parameters are cleared to zero at that point.
- R2: A walk emits exactly ROWS records (306 by default) and then goes idle, with no further reads or records. A frame-start pulse during a walk has no effect on that walk.
- R3: For a descriptor at address A, the word at A is the record's line address and the word at A+2 is the link word.
- R4: Link bit 0 set flips the cursor-enable state. The flipped state appears in this row's record and every later record until flipped again.
- R5: If link bit 1 is set, the next descriptor is at (link AND NOT 7) + 4 and is extended. Otherwise the next descriptor is at link AND NOT 3 and is plain. The first descriptor of a frame is plain.
- R6: An extended descriptor's auxiliary word is {word at A-2, word at A-4} (high, low). Its aux kind is 1 (control) when the previous link's bit 2 is 0, and 2 (palette) when it is 1. Plain rows carry kind 0 and aux word 0.
- R7: A control word loads the cursor parameters: colour from bits 3:0, graphics type from bit 4, pixel position from bits 7:5, octet position from bits 14:8. These hold on plain and palette rows until the next control row.
- R8: A read holds mem_req high with a stable mem_addr until mem_ack. Read data is taken in the cycle where mem_req and mem_ack are both high.
- R9: If no acknowledge arrives within ACK_TIMEOUT cycles of mem_req being high, the read is abandoned. The current row and all remaining rows of the frame become blank records (rec_blank 1, every other field 0). An acknowledge in the last allowed cycle is still accepted.
- R10: While rec_valid is high and rec_ready is low, the record fields stay unchanged and mem_req stays low.
- R11: After reset, rec_valid and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that starts a walk |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Byte address of the word being read |
| mem_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata | input | 16 | Read data |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Renderer accepts the record |
| rec_line_addr | output | 16 | Pixel-data address for the row |
| rec_cursor_on | output | 1 | Cursor-enable state for the row |
| rec_aux_kind | output | 2 | 0 none, 1 control, 2 palette |
| rec_aux_word | output | 32 | Auxiliary word, high half from A-2 |
| rec_cur_color | output | 4 | Cursor colour |
| rec_cur_graphic | output | 1 | Cursor type, 1 = graphics |
| rec_cur_pixel | output | 3 | Graphics cursor pixel within octet |
| rec_cur_octet | output | 7 | Cursor octet position in the line |
| rec_blank | output | 1 | Row emitted after an aborted read |

## Verification
The hardest case to reach is an abort in the middle of a frame, on one particular read, after cursor state has already built up. The memory model in the bench can be told to never answer one chosen address, such as the high auxiliary word of a control descriptor deep in a looping chain. The expected records switch to blank from that row on. A second boundary sets every acknowledge latency to exactly the limit and one cycle under it. Cursor persistence comes from chains that loop, so toggles and control reloads recur many times across the 306 rows.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    AUX_NONE = 2'd0,
    AUX_CTRL = 2'd1,
    AUX_PAL  = 2'd2
  } aux_kind_e;

  typedef struct packed {
    logic [6:0] octet;
    logic [2:0] pixel;
    logic       graphic;
    logic [3:0] color;
  } cursor_t;

  function automatic cursor_t decode_ctl(input logic [14:0] w);
    cursor_t c;
    c.color   = w[3:0];
    c.graphic = w[4];
    c.pixel   = w[7:5];
    c.octet   = w[14:8];
    return c;
  endfunction
endpackage

// File: rtl/dlf_mem_reader.sv
module dlf_mem_reader #(
  parameter int ACK_TIMEOUT = 16,
  parameter int AW          = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  output logic          done,
  output logic          timed_out
);
  localparam int TW = $clog2(ACK_TIMEOUT + 1);

  logic [TW-1:0] wait_q;

  assign done      = mem_req & mem_ack;
  assign timed_out = mem_req & ~mem_ack & (wait_q == TW'(ACK_TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      wait_q   <= '0;
    end else if (issue) begin
      mem_req  <= 1'b1;
      mem_addr <= issue_addr;
      wait_q   <= '0;
    end else if (done || timed_out) begin
      mem_req  <= 1'b0;
    end else if (mem_req) begin
      wait_q   <= wait_q + 1'b1;
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !timed_out && !issue) |=> (mem_req && $stable(mem_addr)));

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (wait_q < TW'(ACK_TIMEOUT)));
endmodule

// File: rtl/dlf_cursor_track.sv
module dlf_cursor_track
  import dlf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        upd,
  input  logic        tog,
  input  logic        load,
  input  logic [14:0] ctl,
  output logic        on_nxt,
  output cursor_t     par_nxt
);
  logic    on_q;
  cursor_t par_q;

  always_comb begin
    on_nxt  = on_q ^ tog;
    par_nxt = load ? decode_ctl(ctl) : par_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      on_q  <= 1'b0;
      par_q <= '0;
    end else if (upd) begin
      on_q  <= on_nxt;
      par_q <= par_nxt;
    end
  end

  // R7
  par_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(upd && load)) |=> $stable(par_q));
endmodule

// File: rtl/dlist_fetcher.sv
module dlist_fetcher
  import dlf_pkg::*;
#(
  parameter int               ROWS        = 306,
  parameter logic [WORD_W-1:0] START_ADDR = 16'o270,
  parameter int               ACK_TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [WORD_W-1:0] rec_line_addr,
  output logic              rec_cursor_on,
  output logic [1:0]        rec_aux_kind,
  output logic [2*WORD_W-1:0] rec_aux_word,
  output logic [3:0]        rec_cur_color,
  output logic              rec_cur_graphic,
  output logic [2:0]        rec_cur_pixel,
  output logic [6:0]        rec_cur_octet,
  output logic              rec_blank
);
  localparam int RW = $clog2(ROWS + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_OUT} state_e;

  state_e            state_q;
  logic [1:0]        step_q;
  logic [WORD_W-1:0] entry_q, line_q, ptr_q, auxlo_q;
  logic              ext_q, pal_q, aborted_q;
  logic [RW-1:0]     row_q;

  logic [WORD_W-1:0]   rec_line_q;
  logic                rec_cur_q, rec_blank_q;
  aux_kind_e           rec_kind_q;
  logic [2*WORD_W-1:0] rec_aux_q;
  cursor_t             rec_par_q;

  logic              rd_issue, rd_done, rd_tmo;
  logic [WORD_W-1:0] rd_addr, ptr_w, next_a;
  logic              commit, cur_clr, last_row;
  logic              cur_on_n;
  cursor_t           cur_par_n;

  dlf_mem_reader #(.ACK_TIMEOUT(ACK_TIMEOUT), .AW(WORD_W)) u_rd (
    .clk(clk), .rst(rst), .issue(rd_issue), .issue_addr(rd_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .done(rd_done), .timed_out(rd_tmo)
  );

  dlf_cursor_track u_cur (
    .clk(clk), .rst(rst), .clr(cur_clr), .upd(commit), .tog(ptr_w[0]),
    .load(ext_q && !pal_q), .ctl(auxlo_q[14:0]),
    .on_nxt(cur_on_n), .par_nxt(cur_par_n)
  );

  assign ptr_w    = (step_q == 2'd1) ? mem_rdata : ptr_q;
  assign next_a   = ptr_w[1] ? ((ptr_w & ~WORD_W'(7)) + WORD_W'(4))
                             : (ptr_w & ~WORD_W'(3));
  assign last_row = (row_q == RW'(ROWS - 1));
  assign cur_clr  = (state_q == S_IDLE) && frame_start;

  always_comb begin
    rd_issue = 1'b0;
    rd_addr  = entry_q;
    commit   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (frame_start) begin
          rd_issue = 1'b1;
          rd_addr  = START_ADDR;
        end
      end
      S_READ: begin
        if (rd_done) begin
          unique case (step_q)
            2'd0: begin rd_issue = 1'b1; rd_addr = entry_q + WORD_W'(2); end
            2'd1: begin
              if (ext_q) begin rd_issue = 1'b1; rd_addr = entry_q - WORD_W'(4); end
              else commit = 1'b1;
            end
            2'd2: begin rd_issue = 1'b1; rd_addr = entry_q - WORD_W'(2); end
            default: commit = 1'b1;
          endcase
        end
      end
      default: begin
        if (rec_ready && !last_row && !aborted_q) rd_issue = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      step_q      <= 2'd0;
      entry_q     <= '0;
      line_q      <= '0;
      ptr_q       <= '0;
      auxlo_q     <= '0;
      ext_q       <= 1'b0;
      pal_q       <= 1'b0;
      aborted_q   <= 1'b0;
      row_q       <= '0;
      rec_line_q  <= '0;
      rec_cur_q   <= 1'b0;
      rec_kind_q  <= AUX_NONE;
      rec_aux_q   <= '0;
      rec_par_q   <= '0;
      rec_blank_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (frame_start) begin
            state_q   <= S_READ;
            step_q    <= 2'd0;
            entry_q   <= START_ADDR;
            ext_q     <= 1'b0;
            pal_q     <= 1'b0;
            aborted_q <= 1'b0;
            row_q     <= '0;
          end
        end
        S_READ: begin
          if (rd_tmo) begin
            aborted_q   <= 1'b1;
            state_q     <= S_OUT;
            step_q      <= 2'd0;
            rec_line_q  <= '0;
            rec_cur_q   <= 1'b0;
            rec_kind_q  <= AUX_NONE;
            rec_aux_q   <= '0;
            rec_par_q   <= '0;
            rec_blank_q <= 1'b1;
          end else if (rd_done) begin
            unique case (step_q)
              2'd0: begin line_q <= mem_rdata; step_q <= 2'd1; end
              2'd1: begin ptr_q <= mem_rdata; if (ext_q) step_q <= 2'd2; end
              2'd2: begin auxlo_q <= mem_rdata; step_q <= 2'd3; end
              default: ;
            endcase
            if (commit) begin
              state_q     <= S_OUT;
              step_q      <= 2'd0;
              rec_line_q  <= line_q;
              rec_cur_q   <= cur_on_n;
              rec_par_q   <= cur_par_n;
              rec_kind_q  <= !ext_q ? AUX_NONE : (pal_q ? AUX_PAL : AUX_CTRL);
              rec_aux_q   <= ext_q ? {mem_rdata, auxlo_q} : '0;
              rec_blank_q <= 1'b0;
              entry_q     <= next_a;
              ext_q       <= ptr_w[1];
              pal_q       <= ptr_w[2];
            end
          end
        end
        default: begin
          if (rec_ready) begin
            row_q <= row_q + 1'b1;
            if (last_row)        state_q <= S_IDLE;
            else if (!aborted_q) state_q <= S_READ;
          end
        end
      endcase
    end
  end

  assign rec_valid       = (state_q == S_OUT);
  assign rec_line_addr   = rec_line_q;
  assign rec_cursor_on   = rec_cur_q;
  assign rec_aux_kind    = rec_kind_q;
  assign rec_aux_word    = rec_aux_q;
  assign rec_cur_color   = rec_par_q.color;
  assign rec_cur_graphic = rec_par_q.graphic;
  assign rec_cur_pixel   = rec_par_q.pixel;
  assign rec_cur_octet   = rec_par_q.octet;
  assign rec_blank       = rec_blank_q;

  // R10
  no_read_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !mem_req);

  // R10
  record_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_line_addr) &&
      $stable(rec_aux_word) && $stable(rec_cursor_on) && $stable(rec_blank) &&
      $stable(rec_aux_kind)));

  // R9
  blank_fields_chk: assert property (@(posedge clk) disable iff (rst)
    rec_blank |-> (rec_aux_kind == 2'd0 && !rec_cursor_on && rec_line_addr == '0 &&
      rec_aux_word == '0));

  // R2
  row_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |-> (row_q < RW'(ROWS)));
endmodule

// File: tb/dlist_fetcher_bench.sv
module dlist_fetcher_bench;
  localparam int ROWS = 306;
  localparam int TO   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        mem_req, mem_ack = 1'b0;
  logic [15:0] mem_addr, mem_rdata = '0;
  logic        rec_valid, rec_ready = 1'b1;
  logic [15:0] rec_line_addr;
  logic        rec_cursor_on, rec_cur_graphic, rec_blank;
  logic [1:0]  rec_aux_kind;
  logic [31:0] rec_aux_word;
  logic [3:0]  rec_cur_color;
  logic [2:0]  rec_cur_pixel;
  logic [6:0]  rec_cur_octet;

  always #10 clk = ~clk;

  dlist_fetcher #(.ROWS(ROWS), .START_ADDR(16'o270), .ACK_TIMEOUT(TO)) u_dlist_fetcher (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_line_addr(rec_line_addr),
    .rec_cursor_on(rec_cursor_on), .rec_aux_kind(rec_aux_kind), .rec_aux_word(rec_aux_word),
    .rec_cur_color(rec_cur_color), .rec_cur_graphic(rec_cur_graphic),
    .rec_cur_pixel(rec_cur_pixel), .rec_cur_octet(rec_cur_octet), .rec_blank(rec_blank)
  );

  int total = 0, passed = 0, cyc = 0;
  int lat = 0;
  logic [16:0] hang = 17'h1ffff;
  logic [15:0] mem [0:2047];

  logic [15:0] e_line [ROWS];
  logic        e_cur  [ROWS];
  logic [1:0]  e_kind [ROWS];
  logic [31:0] e_aux  [ROWS];
  logic [14:0] e_par  [ROWS];
  logic        e_blank[ROWS];

  task automatic chk(input bit ok, input string tag, input string msg);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: %s", tag, msg);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 180000) begin
      total++;
      $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  // memory responder
  initial begin
    int waitc = 0;
    forever begin
      @(negedge clk);
      begin
        bit consumed = mem_ack;
        mem_ack = 1'b0;
        if (consumed || !mem_req) waitc = 0;
        if (mem_req) begin
          if ({1'b0, mem_addr} != hang && waitc >= lat) begin
            mem_ack   = 1'b1;
            mem_rdata = mem[mem_addr[11:1]];
          end else waitc++;
        end
      end
    end
  end

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem[a[11:1]];
  endfunction

  task automatic put(input logic [15:0] a, input logic [15:0] v);
    mem[a[11:1]] = v;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
  endtask

  // expected record model from the requirements
  task automatic build_exp();
    logic [15:0] a = 16'o270, p, lo, hi;
    logic ext = 0, pal = 0, cur = 0, ab = 0;
    logic [14:0] par = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (!ab) begin
        if (lat >= TO || {1'b0, a} == hang || {1'b0, a + 16'd2} == hang ||
            (ext && ({1'b0, a - 16'd4} == hang || {1'b0, a - 16'd2} == hang)))
          ab = 1;
      end
      if (ab) begin
        e_line[r] = 0; e_cur[r] = 0; e_kind[r] = 0; e_aux[r] = 0; e_par[r] = 0; e_blank[r] = 1;
      end else begin
        p = rd(a + 16'd2);
        cur ^= p[0];
        e_line[r] = rd(a);
        e_blank[r] = 0;
        if (ext) begin
          lo = rd(a - 16'd4); hi = rd(a - 16'd2);
          e_kind[r] = pal ? 2'd2 : 2'd1;
          e_aux[r] = {hi, lo};
          if (!pal) par = lo[14:0];
        end else begin
          e_kind[r] = 0; e_aux[r] = 0;
        end
        e_cur[r] = cur;
        e_par[r] = par;
        ext = p[1]; pal = p[2];
        a = p[1] ? ((p & ~16'd7) + 16'd4) : (p & ~16'd3);
      end
    end
  endtask

  task automatic run_frame(input string tag, input bit stall, input bit mid_fs);
    int r = 0, hold = 0, guard = 0;
    bit fs_done = 0;
    logic [15:0] s_line;
    logic [31:0] s_aux;
    build_exp();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    chk(mem_req && mem_addr == 16'o270, "R1",
        $sformatf("first read req=%0b addr=%o expected req=1 addr=270", mem_req, mem_addr));
    while (r < ROWS && guard < 60000) begin
      @(negedge clk);
      guard++;
      frame_start = 1'b0;
      if (mid_fs && r == 150 && !fs_done) begin frame_start = 1'b1; fs_done = 1; end
      if (rec_valid) begin
        if (stall && (r % 3 == 0) && hold < 3) begin
          if (hold > 0)
            chk(!mem_req && rec_line_addr == s_line && rec_aux_word == s_aux, "R10",
                $sformatf("stall row %0d req=%0b line=%h aux=%h expected req=0 line=%h aux=%h",
                          r, mem_req, rec_line_addr, rec_aux_word, s_line, s_aux));
          s_line = rec_line_addr; s_aux = rec_aux_word;
          hold++;
          rec_ready = 1'b0;
        end else begin
          rec_ready = 1'b1;
          hold = 0;
          chk(rec_line_addr == e_line[r] && rec_cursor_on == e_cur[r] && rec_aux_kind == e_kind[r] &&
              rec_aux_word == e_aux[r] && rec_blank == e_blank[r] &&
              {rec_cur_octet, rec_cur_pixel, rec_cur_graphic, rec_cur_color} == e_par[r], tag,
              $sformatf("row %0d got line=%h cur=%0b kind=%0d aux=%h par=%h blank=%0b expected line=%h cur=%0b kind=%0d aux=%h par=%h blank=%0b",
                        r, rec_line_addr, rec_cursor_on, rec_aux_kind, rec_aux_word,
                        {rec_cur_octet, rec_cur_pixel, rec_cur_graphic, rec_cur_color}, rec_blank,
                        e_line[r], e_cur[r], e_kind[r], e_aux[r], e_par[r], e_blank[r]));
          r++;
        end
      end else rec_ready = stall ? 1'b0 : 1'b1;
    end
    frame_start = 1'b0;
    rec_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk(r == ROWS && !rec_valid && !mem_req, "R2",
        $sformatf("after frame rows=%0d valid=%0b req=%0b expected rows=%0d valid=0 req=0",
                  r, rec_valid, mem_req, ROWS));
  endtask

  // plain chain: R3, R4, R5 (loop of three, two toggles per pass)
  task automatic load_plain();
    clear_mem();
    put(16'o270, 16'o100000); put(16'o272, 16'o300 | 16'd1);
    put(16'o300, 16'o100120); put(16'o302, 16'o314);
    put(16'o314, 16'o101234); put(16'o316, 16'o270 | 16'd1);
  endtask

  // extended chain: R6, R7 (control, palette, plain, control with odd link bits)
  task automatic load_ext();
    clear_mem();
    put(16'o270, 16'o110000); put(16'o272, 16'o400 | 16'd2);
    put(16'o400, 16'h3A5B);   put(16'o402, 16'h0012);
    put(16'o404, 16'o111000); put(16'o406, 16'o420 | 16'd7);
    put(16'o420, 16'h7777);   put(16'o422, 16'h1234);
    put(16'o424, 16'o112000); put(16'o426, 16'o440);
    put(16'o440, 16'o113000); put(16'o442, 16'o500 | 16'd3);
    put(16'o500, 16'h0147);   put(16'o502, 16'h0005);
    put(16'o504, 16'o114000); put(16'o506, 16'o270);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!rec_valid && !mem_req, "R11",
        $sformatf("in reset valid=%0b req=%0b expected 0 0", rec_valid, mem_req));
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rec_valid && !mem_req, "R11",
        $sformatf("after reset valid=%0b req=%0b expected 0 0", rec_valid, mem_req));
  endtask

  task automatic t_plain();      lat = 0; hang = 17'h1ffff; load_plain(); run_frame("R3 R4 R5", 0, 0); endtask
  task automatic t_extended();   lat = 2; hang = 17'h1ffff; load_ext();   run_frame("R6 R7", 0, 0); endtask
  task automatic t_stall();      lat = 1; hang = 17'h1ffff; load_ext();   run_frame("R10 R2", 1, 1); endtask
  task automatic t_slow_ack();   lat = TO - 1; hang = 17'h1ffff; load_plain(); run_frame("R8 R9", 0, 0); endtask
  task automatic t_hang();       lat = 1; hang = {1'b0, 16'o502}; load_ext(); run_frame("R9", 0, 0); endtask
  task automatic t_late();       lat = TO; hang = 17'h1ffff; load_plain(); run_frame("R9", 0, 0); endtask
  task automatic t_recover();    lat = 0; hang = 17'h1ffff; load_ext();   run_frame("R9 R1", 0, 0); endtask

  initial begin
    t_reset();
    t_plain();
    t_extended();
    t_stall();
    t_slow_ack();
    t_hang();
    t_late();
    t_recover();
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule